// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two buses, called port A and port B, through a pair of storage registers. One register holds a copy of A taken toward B. The other holds a copy of B taken toward A. Each register loads on the rising edge of its own capture pin. A select picks either the live data from the opposite port or the stored copy for the port that is driven. An active-low output enable and a direction input decide which port is driven, if either is.

The datapath is split into independent halves. Each half has its own enable, direction, two capture pins and two selects. Tying the controls of all halves together gives one wide transceiver. Each tri-state pin is split into an input vector, an output vector and a per-bit drive-enable vector.

The capture pins are asynchronous to the system clock. A synchronizer and an edge detector turn each rising edge into a single-cycle capture strike. The drive enables and the driven data are registered, so the driven value changes only on a system clock edge.

Top module: `reg_xcvr`

## Requirements
- R1: A rising edge on `cap_ab[h]` loads the half-h slice of `a_in` into that half's A-to-B register. A rising edge on `cap_ba[h]` loads the slice of `b_in` into the B-to-A register. The load happens at the third system clock edge after the pin is first seen high, using the data present at that edge.
- R2: Loading happens whatever the values of `out_en_n` and `to_b`, including while the half drives port A or port B.
- R3: While `out_en_n[h]` is 1, the half drives neither port from the next clock edge on. Both of its registers still load on capture edges.
- R4: Without a capture edge, a storage register keeps its value.
- R5: With `out_en_n[h]`=0 and `to_b[h]`=0, that half of `a_oe` is all ones one clock later. If `use_st_ba[h]`=0, `a_out` shows the live `b_in` slice from the previous edge. If `use_st_ba[h]`=1, it shows the B-to-A register.
- R6: With `out_en_n[h]`=0 and `to_b[h]`=1, that half of `b_oe` is all ones one clock later. If `use_st_ab[h]`=0, `b_out` shows the live `a_in` slice. If `use_st_ab[h]`=1, it shows the A-to-B register.
- R7: `a_oe` and `b_oe` of a half are never both asserted.
- R8: At the clock edge where `to_b[h]` differs from its value at the previous edge, both drive enables of that half go low for one cycle.
- R9: The halves are independent. Controls and capture edges of one half do not change the outputs or the registers of another half.
- R10: A synchronous active-high `rst` clears both registers of every half to zero and deasserts every drive enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| out_en_n | input | NUM_HALVES | Per-half active-low output enable |
| to_b | input | NUM_HALVES | Per-half direction: 1 drives port B, 0 drives port A |
| cap_ab | input | NUM_HALVES | Per-half capture pin for the A-to-B register |
| cap_ba | input | NUM_HALVES | Per-half capture pin for the B-to-A register |
| use_st_ab | input | NUM_HALVES | Per-half select: 1 sends stored A-to-B data to B |
| use_st_ba | input | NUM_HALVES | Per-half select: 1 sends stored B-to-A data to A |
| a_in | input | NUM_HALVES*HALF_W | Port A pin input values |
| a_out | output | NUM_HALVES*HALF_W | Port A pin output values |
| a_oe | output | NUM_HALVES*HALF_W | Port A per-bit drive enable |
| b_in | input | NUM_HALVES*HALF_W | Port B pin input values |
| b_out | output | NUM_HALVES*HALF_W | Port B pin output values |
| b_oe | output | NUM_HALVES*HALF_W | Port B per-bit drive enable |

## Verification
The assertions check on every cycle that the two drive enables of a half are never both high and that isolation and direction changes blank them. They also check that a strike loads the register from the port and that the register holds otherwise, that strikes last one cycle, and that live data reaches port A one cycle later. Only the bench scenarios can show that a value loaded during isolation or while driving appears later on the selected port, and that the halves do not disturb one another. The same holds for the full truth table across the enable, direction and select settings.

// File: rtl/reg_xcvr_pkg.sv
package reg_xcvr_pkg;
  typedef enum logic {
    DRIVE_PORT_A = 1'b0,
    DRIVE_PORT_B = 1'b1
  } xcvr_dir_e;

  typedef struct packed {
    logic      out_en_n;
    xcvr_dir_e dir;
    logic      use_st_ab;
    logic      use_st_ba;
  } xcvr_ctrl_t;
endpackage

// File: rtl/xcvr_edge_sync.sv
module xcvr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic strike_o
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[LEN-2:0], pin_i};
  end

  assign strike_o = shift_q[STAGES-1] & ~shift_q[STAGES];

  // R1: a rising edge yields a strike lasting exactly one cycle
  a_r1_single_strike: assert property (@(posedge clk) disable iff (rst)
    strike_o |=> !strike_o);
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
  import reg_xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  xcvr_ctrl_t   ctrl_i,
  input  logic         cap_ab_i,
  input  logic         cap_ba_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  logic         strike_ab, strike_ba;
  logic [W-1:0] store_ab_q, store_ba_q;
  logic [W-1:0] a_q, b_q;
  logic         drv_a_q, drv_b_q;
  xcvr_dir_e    dir_q;
  logic         dir_flip;

  xcvr_edge_sync #(.STAGES(STAGES)) u_sync_ab (
    .clk(clk), .rst(rst), .pin_i(cap_ab_i), .strike_o(strike_ab));
  xcvr_edge_sync #(.STAGES(STAGES)) u_sync_ba (
    .clk(clk), .rst(rst), .pin_i(cap_ba_i), .strike_o(strike_ba));

  // Storage registers load on strikes; output settings play no part.
  always_ff @(posedge clk) begin
    if (rst) begin
      store_ab_q <= '0;
      store_ba_q <= '0;
    end else begin
      if (strike_ab) store_ab_q <= a_i;
      if (strike_ba) store_ba_q <= b_i;
    end
  end

  assign dir_flip = (ctrl_i.dir != dir_q);

  // Registered select and data: the driven value only moves on clk.
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= DRIVE_PORT_A;
      drv_a_q <= 1'b0;
      drv_b_q <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
    end else begin
      dir_q   <= ctrl_i.dir;
      drv_a_q <= ~ctrl_i.out_en_n & ~dir_flip & (ctrl_i.dir == DRIVE_PORT_A);
      drv_b_q <= ~ctrl_i.out_en_n & ~dir_flip & (ctrl_i.dir == DRIVE_PORT_B);
      a_q     <= ctrl_i.use_st_ba ? store_ba_q : b_i;
      b_q     <= ctrl_i.use_st_ab ? store_ab_q : a_i;
    end
  end

  assign a_o    = a_q;
  assign b_o    = b_q;
  assign a_oe_o = {W{drv_a_q}};
  assign b_oe_o = {W{drv_b_q}};

  // R7: never drive both ports
  a_r7_one_port: assert property (@(posedge clk) disable iff (rst)
    !(drv_a_q && drv_b_q));
  // R3: isolation releases both ports
  a_r3_isolate: assert property (@(posedge clk) disable iff (rst)
    ctrl_i.out_en_n |=> (!drv_a_q && !drv_b_q));
  // R8: a direction change blanks both enables
  a_r8_dir_blank: assert property (@(posedge clk) disable iff (rst)
    dir_flip |=> (!drv_a_q && !drv_b_q));
  // R1: a strike loads port A data
  a_r1_load_ab: assert property (@(posedge clk) disable iff (rst)
    strike_ab |=> (store_ab_q == $past(a_i)));
  // R4: no strike, no change
  a_r4_hold_ba: assert property (@(posedge clk) disable iff (rst)
    !strike_ba |=> $stable(store_ba_q));
  // R5: live B data reaches A one cycle later
  a_r5_live_to_a: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_i.out_en_n && ctrl_i.dir == DRIVE_PORT_A && !dir_flip && !ctrl_i.use_st_ba)
    |=> (drv_a_q && a_o == $past(b_i)));
endmodule

// File: rtl/reg_xcvr.sv
module reg_xcvr
  import reg_xcvr_pkg::*;
#(
  parameter int NUM_HALVES  = 2,
  parameter int HALF_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_HALVES-1:0]        out_en_n,
  input  logic [NUM_HALVES-1:0]        to_b,
  input  logic [NUM_HALVES-1:0]        cap_ab,
  input  logic [NUM_HALVES-1:0]        cap_ba,
  input  logic [NUM_HALVES-1:0]        use_st_ab,
  input  logic [NUM_HALVES-1:0]        use_st_ba,
  input  logic [NUM_HALVES*HALF_W-1:0] a_in,
  output logic [NUM_HALVES*HALF_W-1:0] a_out,
  output logic [NUM_HALVES*HALF_W-1:0] a_oe,
  input  logic [NUM_HALVES*HALF_W-1:0] b_in,
  output logic [NUM_HALVES*HALF_W-1:0] b_out,
  output logic [NUM_HALVES*HALF_W-1:0] b_oe
);
  localparam int TOTAL_W = NUM_HALVES * HALF_W;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    xcvr_ctrl_t ctrl;
    assign ctrl.out_en_n  = out_en_n[h];
    assign ctrl.dir       = xcvr_dir_e'(to_b[h]);
    assign ctrl.use_st_ab = use_st_ab[h];
    assign ctrl.use_st_ba = use_st_ba[h];

    xcvr_half #(.W(HALF_W), .STAGES(SYNC_STAGES)) u_half (
      .clk     (clk),
      .rst     (rst),
      .ctrl_i  (ctrl),
      .cap_ab_i(cap_ab[h]),
      .cap_ba_i(cap_ba[h]),
      .a_i     (a_in[h*HALF_W +: HALF_W]),
      .b_i     (b_in[h*HALF_W +: HALF_W]),
      .a_o     (a_out[h*HALF_W +: HALF_W]),
      .a_oe_o  (a_oe[h*HALF_W +: HALF_W]),
      .b_o     (b_out[h*HALF_W +: HALF_W]),
      .b_oe_o  (b_oe[h*HALF_W +: HALF_W])
    );
  end

  // R7: across the whole width no bit drives both ports
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    (a_oe & b_oe) == {TOTAL_W{1'b0}});
endmodule

// File: tb/reg_xcvr_tb_top.sv
`timescale 1ns/1ps
module reg_xcvr_tb_top;
  localparam int NH = 2;
  localparam int HW = 8;
  localparam int W  = NH * HW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NH-1:0] out_en_n = '1, to_b = '0, cap_ab = '0, cap_ba = '0;
  logic [NH-1:0] use_st_ab = '0, use_st_ba = '0;
  logic [W-1:0]  a_in = '0, b_in = '0;
  logic [W-1:0]  a_out, a_oe, b_out, b_oe;

  int n_checks = 0;
  int n_fail   = 0;
  logic [W-1:0] st_ab = '0, st_ba = '0;

  always #2.5 clk = ~clk;

  reg_xcvr #(.NUM_HALVES(NH), .HALF_W(HW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .out_en_n(out_en_n), .to_b(to_b),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .use_st_ab(use_st_ab), .use_st_ba(use_st_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  // Vector: {out_en_n, to_b, use_st_ab, use_st_ba, a_in, b_in}
  localparam logic [39:0] VEC [8] = '{
    {2'b00, 2'b00, 2'b00, 2'b00, 16'h1122, 16'h3344},
    {2'b00, 2'b00, 2'b00, 2'b11, 16'h1122, 16'h3344},
    {2'b00, 2'b11, 2'b00, 2'b00, 16'hABCD, 16'h0F0F},
    {2'b00, 2'b11, 2'b11, 2'b00, 16'hABCD, 16'h0F0F},
    {2'b00, 2'b01, 2'b10, 2'b01, 16'h7788, 16'h99AA},
    {2'b00, 2'b10, 2'b01, 2'b10, 16'h6655, 16'h4433},
    {2'b01, 2'b00, 2'b00, 2'b10, 16'hFEDC, 16'hBA98},
    {2'b11, 2'b11, 2'b11, 2'b11, 16'h0001, 16'h8000}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Raise capture pins, hold long enough for the strike, then lower.
  task automatic pulse(input logic [NH-1:0] ab_m, input logic [NH-1:0] ba_m);
    cap_ab = ab_m;
    cap_ba = ba_m;
    cycles(5);
    cap_ab = '0;
    cap_ba = '0;
    cycles(4);
    for (int h = 0; h < NH; h++) begin
      if (ab_m[h]) st_ab[h*HW +: HW] = a_in[h*HW +: HW];
      if (ba_m[h]) st_ba[h*HW +: HW] = b_in[h*HW +: HW];
    end
  endtask

  // Reference truth table built from R3, R5, R6, R7
  task automatic expect_ports(output logic [W-1:0] ea_oe, output logic [W-1:0] ea,
                              output logic [W-1:0] eb_oe, output logic [W-1:0] eb);
    ea_oe = '0; eb_oe = '0; ea = '0; eb = '0;
    for (int h = 0; h < NH; h++) begin
      if (!out_en_n[h] && !to_b[h]) begin
        ea_oe[h*HW +: HW] = '1;
        ea[h*HW +: HW] = use_st_ba[h] ? st_ba[h*HW +: HW] : b_in[h*HW +: HW];
      end
      if (!out_en_n[h] && to_b[h]) begin
        eb_oe[h*HW +: HW] = '1;
        eb[h*HW +: HW] = use_st_ab[h] ? st_ab[h*HW +: HW] : a_in[h*HW +: HW];
      end
    end
  endtask

  task automatic check_table(input string req);
    logic [W-1:0] ea_oe, ea, eb_oe, eb;
    expect_ports(ea_oe, ea, eb_oe, eb);
    check({req, " a_oe"}, a_oe, ea_oe);
    check({req, " b_oe"}, b_oe, eb_oe);
    check({req, " a_out"}, a_out & ea_oe, ea);
    check({req, " b_out"}, b_out & eb_oe, eb);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R10: reset state
    cycles(3);
    check("R10 a_oe in reset", a_oe, '0);
    check("R10 b_oe in reset", b_oe, '0);
    rst = 1'b0;
    out_en_n = '0; to_b = '0; use_st_ba = '1;
    cycles(3);
    check("R10 cleared B-to-A register on A", a_out, '0);
    to_b = '1; use_st_ab = '1;
    cycles(3);
    check("R10 cleared A-to-B register on B", b_out, '0);

    // R3: load both registers while isolated
    out_en_n = '1;
    a_in = 16'hC3A5; b_in = 16'h96E1;
    pulse('1, '1);
    check("R3 no A drive in isolation", a_oe, '0);
    check("R3 no B drive in isolation", b_oe, '0);
    out_en_n = '0; to_b = '0; use_st_ba = '1;
    cycles(3);
    check("R3 isolation-loaded B data on A", a_out, 16'h96E1);
    to_b = '1; use_st_ab = '1;
    cycles(3);
    check("R3 isolation-loaded A data on B", b_out, 16'hC3A5);

    // R5 R6 R7 R4: vector table against the reference truth table
    for (int v = 0; v < 8; v++) begin
      {out_en_n, to_b, use_st_ab, use_st_ba, a_in, b_in} = VEC[v];
      cycles(3);
      check_table($sformatf("R5/R6 vector %0d", v));
    end

    // R2: capture while port A is driven
    out_en_n = '0; to_b = '0; use_st_ba = '0;
    a_in = 16'h5A0F; b_in = 16'h2468;
    cycles(3);
    pulse('1, '0);
    check("R2 A still driven during capture", a_oe, '1);
    check("R5 live B on A", a_out, 16'h2468);
    to_b = '1; use_st_ab = '1;
    cycles(3);
    check("R2 stored A data after driven capture", b_out, 16'h5A0F);

    // R9: strike only the upper half; lower half register must stay
    a_in = 16'h1234;
    pulse(2'b10, 2'b00);
    cycles(1);
    check("R9 upper loaded, lower kept", b_out, 16'h120F);
    out_en_n = 2'b01;
    cycles(3);
    check("R9 per-half B enable", b_oe, 16'hFF00);
    check("R9 per-half A enable", a_oe, 16'h0000);

    // R8: direction flip blanks one cycle then the new port drives
    out_en_n = '0; to_b = '0; use_st_ba = '0;
    cycles(3);
    check("R8 A driven before flip", a_oe, '1);
    to_b = '1;
    cycles(1);
    check("R8 A blanked on flip", a_oe, '0);
    check("R8 B blanked on flip", b_oe, '0);
    cycles(1);
    check("R6 B driven after blank", b_oe, '1);

    // R4: registers held through all of the above without strikes
    use_st_ab = '1;
    cycles(2);
    check("R4 A-to-B register held", b_out, st_ab);

    summary();
  end
endmodule